// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column addresses of one SDRAM read or write burst. A start pulse carries a 10-bit starting column, a three-bit length code and a wrap-order bit. From the next clock on, the block presents one column per cycle with a valid flag. On the final beat of a fixed-length burst, it also raises a last-beat flag. Row and bank tracking, data transfer and mode-register handling lie outside the block. A memory controller's command path drives it.

Two wrap orders are supported. In the linear order the column counts upward inside a naturally aligned block of the burst length. In the interleaved order the beat index is XORed into the low column bits. A whole-row setting counts through every column and wraps at the row end until something ends it. A stop input ends the current burst. A new start pulse replaces the burst on any cycle, with no minimum spacing between commands. Settings that are not allowed are rejected and reported on an error pulse.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is asserted, and after its release until a start is taken, `beat_valid_o`, `beat_last_o` and `bad_cfg_o` are low.
- R2: A legal start sampled at a clock edge makes the following cycle beat 0, with `beat_valid_o` high and `col_o` equal to the start column. Each later clock advances one beat.
- R3: Length codes 0, 1, 2 and 3 select burst lengths 1, 2, 4 and 8. With `interleave_i`=0, beat n presents the start column with its low log2(BL) bits replaced by (start low bits + n) mod BL. The upper bits are unchanged.
- R4: With `interleave_i`=1 and a fixed length, beat n presents the start column with its low log2(BL) bits XORed with n.
- R5: Length code 7 with `interleave_i`=0 is a whole-row burst. Beat n presents (start + n) mod 1024, the burst continues until it is stopped or replaced, and `beat_last_o` never rises during it.
- R6: For a fixed length, `beat_last_o` is high exactly on beat BL-1. When no new start is taken, `beat_valid_o` is low in the cycle after that beat.
- R7: Length codes 4, 5 and 6 with either order, and code 7 with `interleave_i`=1, are illegal. A start carrying one of them gives `bad_cfg_o` high for exactly the next cycle. It produces no beat and ends any burst in progress.
- R8: A `stop_i` sampled without a start makes `beat_valid_o` low from the next cycle. A stop with no burst in progress has no visible effect.
- R9: A start sampled during a burst, including together with `stop_i`, replaces the burst: the next cycle is beat 0 of the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start pulse for a new burst |
| start_col_i | input | 10 | Starting column, sampled with `start_i` |
| len_code_i | input | 3 | Burst length code, sampled with `start_i` |
| interleave_i | input | 1 | Wrap order: 0 linear, 1 interleaved |
| stop_i | input | 1 | Ends the current burst |
| col_o | output | 10 | Column of the current beat |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| beat_last_o | output | 1 | This beat is the final beat of a fixed-length burst |
| bad_cfg_o | output | 1 | The previous cycle's start carried an illegal setting |

## Verification
The bench builds the block with its default parameters: a 10-bit column and a largest fixed length of 8. With the default column width, a whole-row burst can run past column 1023, so the wrap from the last column back to column 0 becomes observable. With the largest fixed length of 8, the bench can step through every pairing of length, wrap order and start offset inside the aligned block. Random upper column bits show that those bits stay fixed. Random runs of starts, stops and illegal codes then land preemption and termination on every beat position.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int LEN_CODE_W = 3;
  localparam logic [LEN_CODE_W-1:0] ROW_CODE = 3'd7;
endpackage

// File: rtl/sbs_len_decode.sv
module sbs_len_decode
  import sbs_pkg::*;
#(
  parameter int COL_W    = 10,
  parameter int MAX_LOG2 = 3
) (
  input  logic [LEN_CODE_W-1:0] code_i,
  input  logic                  ilv_i,
  output logic [COL_W-1:0]      mask_o,
  output logic                  row_o,
  output logic                  legal_o
);
  logic fixed_len;

  always_comb begin
    fixed_len = (int'(code_i) <= MAX_LOG2);
    row_o     = (code_i == ROW_CODE);
    legal_o   = fixed_len || (row_o && !ilv_i);
  end

  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    assign mask_o[b] = row_o || (int'(code_i) > b);
  end
endmodule

// File: rtl/sbs_col_gen.sv
module sbs_col_gen #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;

  assign sum = base_i + beat_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    always_comb begin
      if (!mask_i[b])
        col_o[b] = base_i[b];
      else if (ilv_i)
        col_o[b] = base_i[b] ^ beat_i[b];
      else
        col_o[b] = sum[b];
    end
  end
endmodule

// File: rtl/sbs_beat_ctrl.sv
module sbs_beat_ctrl #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             reject_i,
  input  logic             stop_i,
  input  logic             row_i,
  input  logic [COL_W-1:0] mask_i,
  output logic             active_o,
  output logic [COL_W-1:0] beat_o,
  output logic             last_o,
  output logic             bad_o
);
  logic             active_q, active_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic             bad_q, bad_d;
  logic             at_end;

  assign at_end = !row_i && (beat_q == mask_i);

  always_comb begin
    active_d = active_q;
    beat_d   = beat_q;
    bad_d    = 1'b0;
    if (take_i) begin
      active_d = 1'b1;
      beat_d   = '0;
    end else if (reject_i) begin
      active_d = 1'b0;
      bad_d    = 1'b1;
    end else if (stop_i) begin
      active_d = 1'b0;
    end else if (active_q) begin
      if (at_end)
        active_d = 1'b0;
      else
        beat_d = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      bad_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      beat_q   <= beat_d;
      bad_q    <= bad_d;
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign last_o   = active_q && at_end;
  assign bad_o    = bad_q;
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
#(
  parameter int COL_W    = 10,
  parameter int MAX_LOG2 = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  interleave_i,
  input  logic                  stop_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  beat_valid_o,
  output logic                  beat_last_o,
  output logic                  bad_cfg_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_row, dec_legal;
  logic             take, reject;

  logic [COL_W-1:0] base_q, mask_q;
  logic             ilv_q, row_q;
  logic [COL_W-1:0] base_d, mask_d;
  logic             ilv_d, row_d;

  logic [COL_W-1:0] beat;

  sbs_len_decode #(.COL_W(COL_W), .MAX_LOG2(MAX_LOG2)) u_dec (
    .code_i (len_code_i),
    .ilv_i  (interleave_i),
    .mask_o (dec_mask),
    .row_o  (dec_row),
    .legal_o(dec_legal)
  );

  assign take   = start_i && dec_legal;
  assign reject = start_i && !dec_legal;

  always_comb begin
    base_d = base_q;
    mask_d = mask_q;
    ilv_d  = ilv_q;
    row_d  = row_q;
    if (take) begin
      base_d = start_col_i;
      mask_d = dec_mask;
      ilv_d  = interleave_i;
      row_d  = dec_row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
      row_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      mask_q <= mask_d;
      ilv_q  <= ilv_d;
      row_q  <= row_d;
    end
  end

  sbs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (take),
    .reject_i(reject),
    .stop_i  (stop_i),
    .row_i   (row_q),
    .mask_i  (mask_q),
    .active_o(beat_valid_o),
    .beat_o  (beat),
    .last_o  (beat_last_o),
    .bad_o   (bad_cfg_o)
  );

  sbs_col_gen #(.COL_W(COL_W)) u_col (
    .base_i(base_q),
    .beat_i(beat),
    .mask_i(mask_q),
    .ilv_i (ilv_q),
    .col_o (col_o)
  );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int COL_W    = 10,
  parameter int MAX_LOG2 = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       len_code_i,
  input logic             interleave_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             beat_valid_o,
  input logic             beat_last_o,
  input logic             bad_cfg_o
);
  logic ok_cfg;
  assign ok_cfg = (int'(len_code_i) <= MAX_LOG2) || (len_code_i == 3'd7 && !interleave_i);

  AST_LAST_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last_o |-> beat_valid_o); // R6

  AST_FIRST_BEAT_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ok_cfg) |=> (beat_valid_o && col_o == $past(start_col_i))); // R2

  AST_BAD_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !ok_cfg) |=> (bad_cfg_o && !beat_valid_o)); // R7

  AST_BAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !bad_cfg_o); // R7

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !beat_valid_o); // R8

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_last_o && !start_i) |=> !beat_valid_o); // R6

  AST_KEEPS_GOING: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !beat_last_o && !start_i && !stop_i) |=> beat_valid_o); // R5
endmodule

bind sdram_burst_seq sbs_checker #(.COL_W(COL_W), .MAX_LOG2(MAX_LOG2)) u_sbs_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .len_code_i  (len_code_i),
  .interleave_i(interleave_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .beat_valid_o(beat_valid_o),
  .beat_last_o (beat_last_o),
  .bad_cfg_o   (bad_cfg_o)
);

// File: tb/test_sdram_burst_seq.sv
module test_sdram_burst_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [9:0] start_col_i;
  logic [2:0] len_code_i;
  logic       interleave_i;
  logic       stop_i;
  logic [9:0] col_o;
  logic       beat_valid_o, beat_last_o, bad_cfg_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench model state
  bit       m_act;
  bit       m_bad;
  int       m_n;
  int       m_base;
  int       m_bl;     // 0 means whole row
  bit       m_ilv;

  always #2 clk = ~clk;

  sdram_burst_seq i_sdram_burst_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i), .stop_i(stop_i),
    .col_o(col_o), .beat_valid_o(beat_valid_o), .beat_last_o(beat_last_o),
    .bad_cfg_o(bad_cfg_o)
  );

  function automatic int len_of(input int code, input bit ilv);
    if (code <= 3) return 1 << code;
    if (code == 7 && !ilv) return 0;
    return -1;
  endfunction

  function automatic int exp_col(input int base, input int bl, input bit ilv, input int n);
    int off;
    if (bl == 0) return (base + n) % 1024;
    off = base % bl;
    if (ilv) return (base - off) + (off ^ n);
    return (base - off) + ((off + n) % bl);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    string ct;
    chk("R8 valid", beat_valid_o, m_act);
    chk("R7 bad_cfg", bad_cfg_o, m_bad);
    if (m_act) begin
      ct = (m_n == 0) ? "R2 col" : (m_bl == 0) ? "R5 col" : m_ilv ? "R4 col" : "R3 col";
      chk(ct, col_o, exp_col(m_base, m_bl, m_ilv, m_n));
      chk((m_bl == 0) ? "R5 last" : "R6 last", beat_last_o, (m_bl != 0 && m_n == m_bl - 1));
    end else begin
      chk("R6 last idle", beat_last_o, 0);
    end
  endtask

  task automatic cyc(input bit st, input int col, input int code, input bit ilv, input bit sp);
    int bl;
    start_i = st; start_col_i = col[9:0]; len_code_i = code[2:0];
    interleave_i = ilv; stop_i = sp;
    @(posedge clk);
    bl = len_of(code, ilv);
    m_bad = 0;
    if (st) begin
      if (bl >= 0) begin
        m_act = 1; m_n = 0; m_base = col; m_bl = bl; m_ilv = ilv;
      end else begin
        m_act = 0; m_bad = 1;
      end
    end else if (sp) begin
      m_act = 0;
    end else if (m_act) begin
      if (m_bl != 0 && m_n == m_bl - 1) m_act = 0;
      else m_n++;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    start_i = 0; start_col_i = 0; len_code_i = 0; interleave_i = 0; stop_i = 0;
    m_act = 0; m_bad = 0; m_n = 0; m_base = 0; m_bl = 1; m_ilv = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", beat_valid_o, 0);
    chk("R1 bad in reset", bad_cfg_o, 0);
    chk("R1 last in reset", beat_last_o, 0);
    rst_n = 1;
    idle(2);

    // R3 R4 R6: every length, order and offset in the aligned block
    for (int code = 0; code <= 3; code++)
      for (int il = 0; il < 2; il++)
        for (int off = 0; off < 8; off++) begin
          int c;
          c = (($urandom % 128) * 8) + off;
          cyc(1, c, code, il[0], 0);
          idle((1 << code) + 1);
        end

    // R5: whole row, run past the row end, then stop
    cyc(1, 1020, 7, 0, 0);
    idle(1030);
    cyc(0, 0, 0, 0, 1);
    idle(2);

    // R7: illegal settings, also while a burst is running
    for (int code = 4; code <= 7; code++) begin
      cyc(1, 5, 3, 0, 0);
      idle(2);
      cyc(1, 9, code, (code == 7) ? 1'b1 : 1'b0, 0);
      idle(2);
      cyc(1, 9, code, 1, 0);
      idle(1);
    end

    // R8: stop mid burst and stop while idle
    cyc(1, 12, 3, 1, 0);
    idle(2);
    cyc(0, 0, 0, 0, 1);
    idle(2);
    cyc(0, 0, 0, 0, 1);

    // R9: replace a burst, including with stop in the same cycle
    cyc(1, 100, 3, 0, 0);
    idle(3);
    cyc(1, 203, 2, 1, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(1, 517, 7, 0, 1);
    idle(4);
    cyc(1, 6, 0, 0, 0);
    cyc(1, 7, 1, 1, 0);
    idle(3);

    // R9: random mix of starts, stops and settings
    for (int i = 0; i < 4000; i++) begin
      bit st, sp;
      int code;
      st = (($urandom % 6) == 0);
      sp = (($urandom % 10) == 0);
      code = (($urandom % 8) < 6) ? ($urandom % 4) : ($urandom % 8);
      cyc(st, $urandom % 1024, code, $urandom % 2, sp);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule